// File: doc/BRIEF.md
# Lower-Part OR Approximate Adder

This block adds two unsigned words and gives up some accuracy in exchange for less logic. The bits of the low segment get no carry logic at all. Each result bit in that segment is the bitwise OR of the two operand bits at the same position. The bits of the high segment come from a ripple chain of full-adder cells. That chain starts with a carry-in of zero, so nothing the low segment does can reach it.

The approximation has a fixed error that only ever goes one way. The result falls short of the true sum by exactly the value of the AND of the two low segments. It is never larger than the true sum. It is exact whenever the low segments share no set bit.

A diagnostic output reports this shortfall as a small two's-complement number. This lets a caller track the accumulated bias without computing the exact sum.

The design is purely combinational and holds no state. The word width and the low-segment width are both parameters. The defaults are a 16-bit word with a 4-bit OR segment.

Top module: `lor_adder`

## Requirements
- R1: Result bits [3:0] equal the bitwise OR of op_a[3:0] and op_b[3:0].
- R2: Result bits [15:4] equal (op_a[15:4] + op_b[15:4]) modulo 4096, computed with a carry-in of zero.
- R3: carry_out is 1 exactly when op_a[15:4] + op_b[15:4] is 4096 or more. The result then wraps modulo 65536.
- R4: The 17-bit value {carry_out, sum} plus (op_a[3:0] & op_b[3:0]) equals the exact 17-bit sum op_a + op_b. In other words, the approximate result minus the exact sum is -(op_a[3:0] & op_b[3:0]).
- R5: As a signed value, the error always lies between -15 and 0 inclusive.
- R6: The error is zero whenever op_a[3:0] & op_b[3:0] is zero.
- R7: deviation is a 5-bit two's-complement value equal to -(op_a[3:0] & op_b[3:0]). For example, 0xF & 0xF gives 5'b10001, which is -15, and a zero AND gives 5'b00000.
- R8: Changing only the low nibbles of the operands leaves sum[15:4] and carry_out unchanged.
- R9: The synthesizable logic uses no multiply operator, only addition and bitwise operators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First unsigned operand |
| op_b | input | 16 | Second unsigned operand |
| sum | output | 16 | Approximate sum, wrapping modulo 2^16 |
| carry_out | output | 1 | Carry out of the top cell of the ripple chain |
| deviation | output | 5 | Signed error of sum relative to the exact sum |

## Verification
The immediate assertions in the top module are evaluated on every change of the operands. They check four things:
- the OR segment (R1);
- the exact-sum identity (R4);
- the error range and the zero-error case (R5, R6);
- the deviation encoding (R7).

Two behaviours need stimulus pairs and cannot be shown by a single evaluation:
- The isolation of the ripple chain from the low nibble (R8) only appears when two operand pairs that differ in their low nibbles are compared.
- The wrap behaviour of carry_out (R3) only appears at the all-ones and overflow corners.

The bench covers these by sweeping all 256 low-nibble pairs under fixed upper halves, and by driving 10,000 pairs from an LFSR.

// File: rtl/lor_adder_pkg.sv
package lor_adder_pkg;
    localparam int unsigned DEF_WIDTH  = 16;
    localparam int unsigned DEF_LOW    = 4;

    // Two's-complement negation of a non-negative value, no multiply (R9)
    function automatic logic [DEF_LOW:0] neg_small(input logic [DEF_LOW-1:0] v);
        return (~{1'b0, v}) + {{DEF_LOW{1'b0}}, 1'b1};
    endfunction
endpackage

// File: rtl/lor_full_adder.sv
module lor_full_adder (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    always_comb begin
        s_o = x_i ^ y_i ^ c_i;
        c_o = (x_i & y_i) | (c_i & (x_i ^ y_i));
    end
endmodule

// File: rtl/lor_ripple_chain.sv
module lor_ripple_chain #(
    parameter int unsigned BITS = 12
) (
    input  logic [BITS-1:0] x_i,
    input  logic [BITS-1:0] y_i,
    output logic [BITS-1:0] s_o,
    output logic            c_o
);
    logic [BITS:0] carry_d;

    // R2: chain starts with no carry in
    assign carry_d[0] = 1'b0;

    for (genvar k = 0; k < BITS; k++) begin : g_cell
        lor_full_adder u_fa (
            .x_i (x_i[k]),
            .y_i (y_i[k]),
            .c_i (carry_d[k]),
            .s_o (s_o[k]),
            .c_o (carry_d[k+1])
        );
    end

    assign c_o = carry_d[BITS];
endmodule

// File: rtl/lor_low_segment.sv
module lor_low_segment #(
    parameter int unsigned BITS = 4
) (
    input  logic [BITS-1:0] x_i,
    input  logic [BITS-1:0] y_i,
    output logic [BITS-1:0] or_o,
    output logic [BITS:0]   dev_o
);
    logic [BITS-1:0] overlap_d;

    always_comb begin
        or_o      = x_i | y_i;
        overlap_d = x_i & y_i;
        dev_o     = (~{1'b0, overlap_d}) + {{BITS{1'b0}}, 1'b1};
    end
endmodule

// File: rtl/lor_adder.sv
module lor_adder #(
    parameter int unsigned WIDTH = lor_adder_pkg::DEF_WIDTH,
    parameter int unsigned LOW   = lor_adder_pkg::DEF_LOW
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic [LOW:0]     deviation
);
    localparam int unsigned HIGH = WIDTH - LOW;

    logic [LOW-1:0]  low_d;
    logic [HIGH-1:0] high_d;
    logic            cout_d;
    logic [LOW:0]    dev_d;

    lor_low_segment #(.BITS(LOW)) u_low (
        .x_i   (op_a[LOW-1:0]),
        .y_i   (op_b[LOW-1:0]),
        .or_o  (low_d),
        .dev_o (dev_d)
    );

    lor_ripple_chain #(.BITS(HIGH)) u_high (
        .x_i (op_a[WIDTH-1:LOW]),
        .y_i (op_b[WIDTH-1:LOW]),
        .s_o (high_d),
        .c_o (cout_d)
    );

    always_comb begin
        sum       = {high_d, low_d};
        carry_out = cout_d;
        deviation = dev_d;
    end

    // Assertions: checked on every change of the operands
    logic [WIDTH:0]   exact_chk;
    logic [WIDTH:0]   approx_chk;
    logic [LOW-1:0]   ovl_chk;
    logic [WIDTH:0]   diff_chk;

    always_comb begin
        exact_chk  = {1'b0, op_a} + {1'b0, op_b};
        approx_chk = {carry_out, sum};
        ovl_chk    = op_a[LOW-1:0] & op_b[LOW-1:0];
        diff_chk   = approx_chk - exact_chk;

        // R1
        low_or_chk: assert (sum[LOW-1:0] == (op_a[LOW-1:0] | op_b[LOW-1:0]))
            else $error("low segment is not the OR of the operands");

        // R4
        exact_identity_chk: assert (approx_chk + {{(WIDTH+1-LOW){1'b0}}, ovl_chk} == exact_chk)
            else $error("approximate plus overlap differs from exact sum");

        // R5
        err_range_chk: assert ($signed(diff_chk) <= 0 && $signed(diff_chk) >= -$signed({1'b0, {LOW{1'b1}}}))
            else $error("error outside the allowed range");

        // R6
        zero_err_chk: assert ((ovl_chk != '0) || (approx_chk == exact_chk))
            else $error("nonzero error with disjoint low segments");

        // R7
        dev_match_chk: assert (deviation == diff_chk[LOW:0])
            else $error("deviation does not match actual error");
    end
endmodule

// File: tb/tb_lor_adder.sv
module tb_lor_adder;
    logic        clk = 1'b0;
    logic [15:0] op_a, op_b;
    logic [15:0] sum;
    logic        carry_out;
    logic [4:0]  deviation;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    int unsigned cycles   = 0;
    bit          done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    lor_adder dut (
        .op_a      (op_a),
        .op_b      (op_b),
        .sum       (sum),
        .carry_out (carry_out),
        .deviation (deviation)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (a=%h b=%h)", req, act, exp, op_a, op_b);
        end
    endtask

    task automatic apply(input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        op_a = a;
        op_b = b;
        #1;
    endtask

    // Full check of one pair against arithmetic expectations
    task automatic check_pair();
        logic [16:0] exact;
        logic [3:0]  ovl;
        logic [12:0] hi;
        logic [4:0]  dv;
        exact = {1'b0, op_a} + {1'b0, op_b};
        ovl   = op_a[3:0] & op_b[3:0];
        hi    = {1'b0, op_a[15:4]} + {1'b0, op_b[15:4]};
        dv    = 5'd0 - {1'b0, ovl};
        check(sum[3:0] == (op_a[3:0] | op_b[3:0]), "R1", sum[3:0], op_a[3:0] | op_b[3:0]);
        check(sum[15:4] == hi[11:0], "R2", sum[15:4], hi[11:0]);
        check(carry_out == hi[12], "R3", carry_out, hi[12]);
        check({carry_out, sum} == exact - ovl, "R4", {carry_out, sum}, exact - ovl);
        check(deviation == dv, "R7", deviation, dv);
        check($signed(deviation) <= 0 && $signed(deviation) >= -15, "R5", deviation, 0);
        if (ovl == 4'd0)
            check({carry_out, sum} == exact, "R6", {carry_out, sum}, exact);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        logic [15:0] ref_hi;
        logic        ref_c;
        op_a = '0;
        op_b = '0;
        #1;
        // reset-state / zero operands
        check(sum == 16'h0 && carry_out == 1'b0, "R1 zero", {carry_out, sum}, 0);
        check(deviation == 5'h00, "R6 zero", deviation, 0);

        // corners
        apply(16'hFFFF, 16'hFFFF);
        check_pair();
        check(sum == 16'hFFEF && carry_out, "R3 all-ones", {carry_out, sum}, 17'h1FFEF);
        check(deviation == 5'b10001, "R7 worst", deviation, 5'b10001);
        apply(16'h000F, 16'h000F);
        check_pair();
        check(sum == 16'h000F, "R5 worst", sum, 16'h000F);
        apply(16'h1235, 16'h4565);
        check_pair();
        apply(16'hFFF0, 16'h0010);
        check_pair();
        check(sum == 16'h0000 && carry_out, "R3 wrap", {carry_out, sum}, 17'h10000);
        apply(16'h000A, 16'h0005);
        check_pair();

        // R8: exhaustive low-nibble sweep under several upper halves
        foreach (ref_hi[i]) begin end
        for (int u = 0; u < 4; u++) begin
            logic [11:0] ua, ub;
            ua = (u == 0) ? 12'h000 : (u == 1) ? 12'hFFF : (u == 2) ? 12'h7A3 : 12'h800;
            ub = (u == 0) ? 12'h000 : (u == 1) ? 12'h001 : (u == 2) ? 12'h25C : 12'h800;
            apply({ua, 4'h0}, {ub, 4'h0});
            ref_hi = sum;
            ref_c  = carry_out;
            for (int la = 0; la < 16; la++) begin
                for (int lb = 0; lb < 16; lb++) begin
                    apply({ua, la[3:0]}, {ub, lb[3:0]});
                    check_pair();
                    check(sum[15:4] == ref_hi[15:4] && carry_out == ref_c, "R8",
                          {carry_out, sum[15:4]}, {ref_c, ref_hi[15:4]});
                end
            end
        end

        // LFSR sweep, maximal-length 32-bit polynomial
        lfsr = 32'hACE1_2357;
        for (int n = 0; n < 10000; n++) begin
            lfsr = lfsr[0] ? ((lfsr >> 1) ^ 32'h8020_0003) : (lfsr >> 1);
            apply(lfsr[15:0], lfsr[31:16]);
            check_pair();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule